// File: doc/BRIEF.md
# Two-Bit Counter Branch Predictor

This block predicts conditional branches for an in-order pipeline. It holds a direct-mapped table of 2-bit saturating counters beside a table of branch targets, each entry guarded by a valid bit. The fetch stage presents its program counter and gets back, in the same cycle, a taken/not-taken guess and the target to steer to.

The execute stage later reports the real result of a resolved branch: its address, whether it was taken, and where it went. That report moves the selected counter one step toward the observed direction. A taken result also records the target and marks the entry as usable. Choosing the next PC, spotting mispredictions and flushing the pipeline stay outside the block.

Top module: `bp_predictor`

## Requirements
- R1: While reset is held and right after it, every entry is invalid with its counter at 01. The outputs are then `pred_taken` = 0 and `pred_target` = 0 for any lookup address.
- R2: Both tables are indexed by `pc[IDX_W+1:2]`, where IDX_W = log2(ENTRIES) and ENTRIES defaults to 1024. Address bits outside that field are ignored, so two addresses with the same field share one entry.
- R3: `pred_taken` is 1 exactly when the looked-up entry is valid and its counter holds 10 or 11.
- R4: The counter encodings are 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A taken update raises the counter by one and stops at 11.
- R5: A not-taken update lowers the counter by one and stops at 00. This also happens when the entry is invalid.
- R6: A taken update stores `upd_target` and sets the entry valid. A lookup of a valid entry returns the stored target on `pred_target`, and a lookup of an invalid entry returns 0.
- R7: A not-taken update leaves the stored target and the valid bit unchanged.
- R8: An update takes effect at the clock edge where `upd_en` is sampled high. A lookup of the same entry in that cycle still returns the old state.
- R9: An entry changes only when an update selects it. With `upd_en` low, all state holds.
- R10: `rst_n` asserts asynchronously. After it rises, the block starts accepting updates only from the third rising clock edge, because updates sampled at the first two edges are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fetch_pc | input | PC_W | Address looked up in the fetch stage |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_target | output | PC_W | Predicted target for fetch_pc, 0 when the entry is invalid |
| upd_en | input | 1 | A resolved branch is being reported |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
The assertions assume that `fetch_pc`, `upd_*` and `upd_en` are driven to known values throughout and only change between clock edges. The target-write property also assumes that the internal reset has fully released before any update it judges. To meet these assumptions, the stimulus changes every input on the falling edge and keeps `upd_en` low until the synchronised reset has ended. The exception is the deliberate test of discarded early updates, in which the checker is still held in reset.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the observed direction
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table import bp_pkg::*; #(
  parameter int unsigned ENTRIES = 1024,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  ctr_e ctr_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    ctr_e ctr_q;
    ctr_e ctr_d;
    logic ce;

    always_comb begin
      ce    = wr_en && (wr_idx == IDX_W'(g));
      ctr_d = ctr_step(ctr_q, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctr_q <= CTR_WNT;
      else if (ce) ctr_q <= ctr_d;
    end

    assign ctr_arr[g] = ctr_q;
  end

  assign rd_ctr = ctr_arr[rd_idx];
endmodule

// File: rtl/bp_target_table.sv
module bp_target_table #(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned PC_W    = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_target
);
  logic            vld_arr [ENTRIES];
  logic [PC_W-1:0] tgt_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic            vld_q;
    logic [PC_W-1:0] tgt_q;
    logic            ce;

    always_comb ce = wr_en && (wr_idx == IDX_W'(g));

    // valid bit is control state: reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vld_q <= 1'b0;
      else if (ce) vld_q <= 1'b1;
    end

    // target is datapath: no reset, guarded by the valid bit
    always_ff @(posedge clk) begin
      if (ce) tgt_q <= wr_target;
    end

    assign vld_arr[g] = vld_q;
    assign tgt_arr[g] = tgt_q;
  end

  assign rd_valid  = vld_arr[rd_idx];
  assign rd_target = tgt_arr[rd_idx];
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor import bp_pkg::*; #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_HI = IDX_W + IDX_LO - 1;

  logic             rst_sync_n;
  logic [IDX_W-1:0] fetch_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_e             rd_ctr;
  logic             rd_valid;
  logic [PC_W-1:0]  rd_target;
  logic             tgt_we;

  bp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    fetch_idx = fetch_pc[IDX_HI:IDX_LO];
    upd_idx   = upd_pc[IDX_HI:IDX_LO];
    tgt_we    = upd_en && upd_taken;
  end

  bp_counter_table #(.ENTRIES(ENTRIES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (fetch_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_en),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  bp_target_table #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_tgt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_idx    (fetch_idx),
    .rd_valid  (rd_valid),
    .rd_target (rd_target),
    .wr_en     (tgt_we),
    .wr_idx    (upd_idx),
    .wr_target (upd_target)
  );

  always_comb begin
    pred_taken  = rd_valid && (rd_ctr == CTR_WT || rd_ctr == CTR_ST);
    pred_target = rd_valid ? rd_target : '0;
  end
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] f_idx;
  logic [IDX_W-1:0] u_idx;
  logic             seen_q;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign u_idx = upd_pc[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!pred_taken && pred_target == '0));

  assert_tgt_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(upd_en && upd_taken) && f_idx == $past(u_idx))
      |-> pred_target == $past(upd_target));

  assert_inc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(upd_en && upd_taken && pred_taken && f_idx == u_idx)
      && $stable(fetch_pc)) |-> pred_taken);

  assert_dec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(upd_en && !upd_taken && !pred_taken && f_idx == u_idx)
      && $stable(fetch_pc)) |-> !pred_taken);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(!upd_en) && $stable(fetch_pc))
      |-> ($stable(pred_taken) && $stable(pred_target)));
endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .fetch_pc    (fetch_pc),
  .pred_taken  (pred_taken),
  .pred_target (pred_target),
  .upd_en      (upd_en),
  .upd_pc      (upd_pc),
  .upd_taken   (upd_taken),
  .upd_target  (upd_target)
);

// File: tb/bp_predictor_test.sv
`timescale 1ns/1ps
module bp_predictor_test;
  localparam int unsigned PC_W = 32;
  localparam int unsigned ENT  = 16;
  localparam int unsigned NV   = 16;

  // {upd_en, upd_taken, upd_pc[15:0], upd_target[15:0], fetch_pc[15:0]}
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b0, 16'h0048, 16'h0999, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b1, 16'h0048, 16'h0020, 16'h0048},
    {1'b1, 1'b0, 16'h0048, 16'h0000, 16'h0048},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0088},
    {1'b1, 1'b0, 16'h0014, 16'h0555, 16'h0014},
    {1'b1, 1'b0, 16'h0014, 16'h0555, 16'h0014},
    {1'b1, 1'b1, 16'h0014, 16'h0300, 16'h0014},
    {1'b1, 1'b1, 16'h0014, 16'h0300, 16'h0014},
    {1'b1, 1'b1, 16'h0014, 16'h0300, 16'h0014},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0014}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] fetch_pc;
  logic            pred_taken;
  logic [PC_W-1:0] pred_target;
  logic            upd_en;
  logic [PC_W-1:0] upd_pc;
  logic            upd_taken;
  logic [PC_W-1:0] upd_target;

  int n_chk  = 0;
  int n_fail = 0;

  int          mdl_ctr [ENT];
  logic        mdl_val [ENT];
  logic [31:0] mdl_tgt [ENT];

  always #2 clk = ~clk;

  bp_predictor #(.PC_W(PC_W), .ENTRIES(ENT)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; upd_en = 1'b0; upd_taken = 1'b0;
    upd_pc = '0; upd_target = '0; fetch_pc = 32'h48;
    for (int e = 0; e < ENT; e++) begin
      mdl_ctr[e] = 1; mdl_val[e] = 1'b0; mdl_tgt[e] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R1 taken in reset", {31'd0, pred_taken}, 32'd0);
    check("R1 target in reset", pred_target, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // loop-branch pattern against the software model
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  li, ui;
      logic [49:0] w;
      logic        et;
      logic [31:0] eg;
      w = VEC[v];
      @(negedge clk);
      upd_en     = w[49];
      upd_taken  = w[48];
      upd_pc     = {16'd0, w[47:32]};
      upd_target = {16'd0, w[31:16]};
      fetch_pc   = {16'd0, w[15:0]};
      #1;
      li = fetch_pc[5:2];
      ui = upd_pc[5:2];
      et = mdl_val[li] && (mdl_ctr[li] >= 2);
      eg = mdl_val[li] ? mdl_tgt[li] : 32'd0;
      check($sformatf("R2/R3/R4/R5/R8 taken vec %0d", v), {31'd0, pred_taken}, {31'd0, et});
      check($sformatf("R6/R7 target vec %0d", v), pred_target, eg);
      if (upd_en) begin
        if (upd_taken) begin
          if (mdl_ctr[ui] < 3) mdl_ctr[ui]++;
          mdl_val[ui] = 1'b1;
          mdl_tgt[ui] = upd_target;
        end else if (mdl_ctr[ui] > 0) begin
          mdl_ctr[ui]--;
        end
      end
    end

    // R9: an entry never addressed keeps its reset state
    @(negedge clk); upd_en = 1'b0; fetch_pc = 32'h3C; #1;
    check("R9 untouched taken", {31'd0, pred_taken}, 32'd0);
    check("R9 untouched target", pred_target, 32'd0);

    // R2: bits above the index field and below bit 2 are ignored
    fetch_pc = 32'h0001_0017; #1;
    check("R2 alias taken", {31'd0, pred_taken}, 32'd1);
    check("R2 alias target", pred_target, 32'h300);

    // R10/R1: asynchronous assertion clears at once
    @(negedge clk); fetch_pc = 32'h48; rst_n = 1'b0; #1;
    check("R10 async reset taken", {31'd0, pred_taken}, 32'd0);
    check("R1 async reset target", pred_target, 32'd0);
    repeat (2) @(negedge clk);

    // R10: updates at the first two edges after release are dropped
    rst_n = 1'b1; upd_en = 1'b1; upd_taken = 1'b1;
    upd_pc = 32'h48; upd_target = 32'h77;
    repeat (2) @(posedge clk);
    @(negedge clk); upd_en = 1'b0; #1;
    check("R10 early update dropped taken", {31'd0, pred_taken}, 32'd0);
    check("R10 early update dropped target", pred_target, 32'd0);
    upd_en = 1'b1;
    @(negedge clk); upd_en = 1'b0; #1;
    check("R10/R1 third edge update taken", {31'd0, pred_taken}, 32'd1);
    check("R10/R6 third edge update target", pred_target, 32'h77);

    finish_run();
  end
endmodule